// File: doc/BRIEF.md
# Trace Sample Packer

This block sits between a processor trace port and the trace RAM. Every cycle in which `smp_valid` is high it takes one trace sample and places it in the next free slot of a 32-bit word. A sample is a 3-bit pipeline status, a packet field and a trace-sync flag. When the last slot of the word is filled, the word goes out on `word_data` together with a one-cycle `word_we` strobe.

The number of slots per word and the bit layout depend on the port width. The width is chosen with a 2-bit configuration input:
- a 4-bit port gives three samples per word;
- an 8-bit port gives two;
- a 16-bit port gives one.

A sample flagged as the trigger cycle has its status field replaced by a fixed trigger code. Its real status is then moved into the low bits of its packet field.

When capture stops, `flush` pushes out a partly filled word, with its empty slots written as zero. Starting and stopping capture, and storing the words, are handled outside this block.

Top module: `trace_sample_packer`

## Requirements
- R1: After reset, `word_we` is 0 and `word_data` is 0.
- R2: Width code 2'b00 selects the 4-bit port. Three slots per word, slot k in bits 8k+7..8k, with status in the slot's bits 2..0, packet bits 3..0 in the slot's bits 6..3, and sync in the slot's bit 7.
- R3: Width code 2'b01 selects the 8-bit port. Two slots per word, based at bits 0 and 12, each with status in base+2..base, packet bits 7..0 in base+10..base+3, and sync in base+11.
- R4: Width codes 2'b10 and 2'b11 select the 16-bit port. One slot per word, with status in bits 2..0, packet in bits 18..3 and sync in bit 19.
- R5: For a sample with `smp_trig` high, the status field holds the trigger code (3'b110 by default). Packet bits 2..0 are replaced by the real status, and packet bits above 2 are kept.
- R6: Every word bit outside the filled slots is written as 0. This covers bits 31..24 in the 4-bit and 8-bit modes and bits 31..20 in the 16-bit mode. Packet input bits above the port width have no effect.
- R7: Slots fill from the lowest to the highest. A word is written, with `word_we` high for exactly one cycle, in the cycle after the sample that fills its last slot was accepted. `word_data` holds its value between writes.
- R8: `flush` with a partly filled word writes that word one cycle later, with its empty slots as zero. `flush` with no slot filled writes nothing. `flush` together with `smp_valid` first places the sample, then writes the word.
- R9: The width used for a word is the width code present when that word's first sample is accepted. Changes of the code while the word is partly filled have no effect on it.
- R10: Cycles with `smp_valid` low neither fill a slot nor write a word, whatever the sample inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| width_cfg | input | 2 | Port width code: 00 = 4-bit, 01 = 8-bit, 1x = 16-bit |
| smp_valid | input | 1 | Sample present this cycle |
| smp_stat | input | 3 | Pipeline status of the sample |
| smp_pkt | input | 16 | Packet field (low bits used according to width) |
| smp_sync | input | 1 | Trace-sync flag of the sample |
| smp_trig | input | 1 | Sample is the trigger cycle |
| flush | input | 1 | Capture stop: write out a partly filled word |
| word_we | output | 1 | Word write strobe |
| word_data | output | 32 | Packed word |

## Verification
The assertions watch, on every cycle, the timing rules that follow from the fill state:
- a completing sample or a flush of a partly filled word is followed by a write;
- an empty flush, or a cycle with no valid sample, writes nothing;
- the latched width stays put while a word is partly filled;
- the top byte of every written word is zero.

The bit layouts of the three widths, the trigger re-encoding, the slot order, and the width change in the middle of a word can only be shown by the bench's scenarios. The bench compares each word with the one its behavioural model builds.

// File: rtl/tpk_pkg.sv
// Package: shared constants and helpers of the trace sample packer.
// Assumes a 32-bit trace RAM word and 3-bit pipeline status.
package tpk_pkg;
    localparam int WORD_W = 32;
    localparam int STAT_W = 3;
    localparam int PKT_W  = 16;
    localparam int NMODE  = 3;

    typedef enum logic [1:0] {
        PW_4   = 2'b00,
        PW_8   = 2'b01,
        PW_16  = 2'b10,
        PW_16B = 2'b11
    } port_w_e;

    // Number of samples that fit in one word for a width code.
    function automatic logic [1:0] slots_for(input logic [1:0] code);
        case (code)
            PW_4:    slots_for = 2'd3;
            PW_8:    slots_for = 2'd2;
            default: slots_for = 2'd1;
        endcase
    endfunction

    // Layout variant index (0: 4-bit, 1: 8-bit, 2: 16-bit) for a width code.
    function automatic int unsigned variant_for(input logic [1:0] code);
        case (code)
            PW_4:    variant_for = 0;
            PW_8:    variant_for = 1;
            default: variant_for = 2;
        endcase
    endfunction
endpackage

// File: rtl/tpk_slot_fmt.sv
// Slot formatter: turns one sample into its bit field, already shifted to
// the given slot position of a word, for the given width code.
// Assumes slot_idx is below the slot count of the mode; purely combinational.
module tpk_slot_fmt
    import tpk_pkg::*;
#(
    parameter logic [STAT_W-1:0] TRIG_CODE = 3'b110
) (
    input  logic [1:0]        mode,
    input  logic [1:0]        slot_idx,
    input  logic [STAT_W-1:0] stat,
    input  logic [PKT_W-1:0]  pkt,
    input  logic              sync,
    input  logic              trig,
    output logic [WORD_W-1:0] slot_word
);
    logic [STAT_W-1:0] stat_eff;
    logic [PKT_W-1:0]  pkt_eff;
    logic [WORD_W-1:0] cand [NMODE];

    // Trigger re-encoding: trigger code in status, real status into packet.
    always_comb begin
        stat_eff = trig ? TRIG_CODE : stat;
        pkt_eff  = trig ? {pkt[PKT_W-1:STAT_W], stat} : pkt;
    end

    // One layout variant per port width; packet width doubles each step.
    for (genvar m = 0; m < NMODE; m++) begin : g_variant
        localparam int PW   = 4 << m;
        localparam int SPAN = PW + STAT_W + 1;
        logic [SPAN-1:0] fld;

        // Field of one sample: sync on top, packet, status at the bottom.
        always_comb begin
            fld     = {sync, pkt_eff[PW-1:0], stat_eff};
            cand[m] = WORD_W'(fld) << (32'(slot_idx) * SPAN);
        end
    end

    // Pick the variant that the width code selects.
    always_comb slot_word = cand[variant_for(mode)];
endmodule

// File: rtl/tpk_accum.sv
// Word accumulator: gathers formatted slots into a word, writes the word
// when its last slot fills or on a flush, and latches the width at the
// first slot of each word. Assumes slot_word arrives already positioned.
module tpk_accum
    import tpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic              in_valid,
    input  logic              flush,
    input  logic [WORD_W-1:0] slot_word,
    output logic [1:0]        eff_mode,
    output logic [1:0]        slot_idx,
    output logic              word_we,
    output logic [WORD_W-1:0] word_data
);
    logic [1:0]        cnt;
    logic [1:0]        mode_q;
    logic [WORD_W-1:0] acc;
    logic [1:0]        n_slots;
    logic              last_slot;
    logic [WORD_W-1:0] merged;

    // Width follows the config only while no slot is filled.
    always_comb begin
        eff_mode  = (cnt == 2'd0) ? cfg_mode : mode_q;
        slot_idx  = cnt;
        n_slots   = slots_for(eff_mode);
        last_slot = (cnt == n_slots - 2'd1);
        merged    = acc | slot_word;
    end

    // Fill state, width latch and word output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            mode_q    <= '0;
            acc       <= '0;
            word_we   <= 1'b0;
            word_data <= '0;
        end else begin
            word_we <= 1'b0;
            if (in_valid) begin
                if (last_slot || flush) begin
                    word_data <= merged;
                    word_we   <= 1'b1;
                    acc       <= '0;
                    cnt       <= '0;
                end else begin
                    acc    <= merged;
                    cnt    <= cnt + 2'd1;
                    mode_q <= eff_mode;
                end
            end else if (flush && cnt != 2'd0) begin
                word_data <= acc;
                word_we   <= 1'b1;
                acc       <= '0;
                cnt       <= '0;
            end
        end
    end

    // A sample filling the last slot is followed by a write.
    assert_full_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt == slots_for(eff_mode) - 2'd1) |=> word_we);

    // A flush with a partly filled word produces a write.
    assert_flush_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !in_valid && cnt != 2'd0) |=> word_we);

    // A flush with nothing held produces no write.
    assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !in_valid && cnt == 2'd0) |=> !word_we);

    // The latched width does not move while a word is partly filled.
    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != 2'd0) |=> (mode_q == $past(mode_q)));

    // No write without a sample or a flush in the cycle before.
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !flush) |=> !word_we);

    // The top byte of a written word is always zero.
    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        word_we |-> (word_data[WORD_W-1:24] == '0));
endmodule

// File: rtl/trace_sample_packer.sv
// Trace sample packer top: joins the slot formatter and the word
// accumulator. Assumes one sample per cycle at most and a 32-bit RAM word.
module trace_sample_packer
    import tpk_pkg::*;
#(
    parameter logic [2:0] TRIG_CODE = 3'b110
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  width_cfg,
    input  logic        smp_valid,
    input  logic [2:0]  smp_stat,
    input  logic [15:0] smp_pkt,
    input  logic        smp_sync,
    input  logic        smp_trig,
    input  logic        flush,
    output logic        word_we,
    output logic [31:0] word_data
);
    logic [1:0]        eff_mode;
    logic [1:0]        slot_idx;
    logic [WORD_W-1:0] slot_word;

    tpk_slot_fmt #(.TRIG_CODE(TRIG_CODE)) u_fmt (
        .mode      (eff_mode),
        .slot_idx  (slot_idx),
        .stat      (smp_stat),
        .pkt       (smp_pkt),
        .sync      (smp_sync),
        .trig      (smp_trig),
        .slot_word (slot_word)
    );

    tpk_accum u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_mode  (width_cfg),
        .in_valid  (smp_valid),
        .flush     (flush),
        .slot_word (slot_word),
        .eff_mode  (eff_mode),
        .slot_idx  (slot_idx),
        .word_we   (word_we),
        .word_data (word_data)
    );
endmodule

// File: tb/trace_sample_packer_test.sv
// Bench: behavioural reference model of the packer, compared every cycle.
module trace_sample_packer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  width_cfg = 2'b00;
    logic        smp_valid = 1'b0;
    logic [2:0]  smp_stat = '0;
    logic [15:0] smp_pkt = '0;
    logic        smp_sync = 1'b0;
    logic        smp_trig = 1'b0;
    logic        flush = 1'b0;
    logic        word_we;
    logic [31:0] word_data;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // model state
    int          m_cnt = 0;
    int          m_pw = 4;
    int          m_n = 3;
    logic [31:0] m_acc = '0;
    logic        exp_we = 1'b0;
    logic [31:0] exp_data = '0;
    string       prev_tag = "R1";

    trace_sample_packer uut (
        .clk(clk), .rst_n(rst_n), .width_cfg(width_cfg), .smp_valid(smp_valid),
        .smp_stat(smp_stat), .smp_pkt(smp_pkt), .smp_sync(smp_sync),
        .smp_trig(smp_trig), .flush(flush), .word_we(word_we), .word_data(word_data)
    );

    always #10 clk = ~clk;

    task automatic compare(input string tag);
        checks++;
        if (word_we !== exp_we || word_data !== exp_data) begin
            fails++;
            $display("FAIL %s: we=%0b data=%08h expected we=%0b data=%08h",
                     tag, word_we, word_data, exp_we, exp_data);
        end
    endtask

    // Reference model: what the packer must do with this cycle's inputs.
    task automatic model(input logic v, input logic [2:0] st, input logic [15:0] pk,
                         input logic sy, input logic tr, input logic fl,
                         input logic [1:0] cfg);
        logic [31:0] fieldv;
        int stv;
        int pkv;
        exp_we = 1'b0;
        if (v) begin
            if (m_cnt == 0) begin
                m_pw = (cfg == 2'b00) ? 4 : (cfg == 2'b01) ? 8 : 16;
                m_n  = (cfg == 2'b00) ? 3 : (cfg == 2'b01) ? 2 : 1;
            end
            pkv = int'(pk) % (1 << m_pw);
            stv = int'(st);
            if (tr) begin
                pkv = (pkv / 8) * 8 + int'(st);
                stv = 6;
            end
            fieldv = 32'(stv) + 32'(pkv) * 8 + (sy ? (32'd1 << (3 + m_pw)) : 32'd0);
            m_acc = m_acc | (fieldv << (m_cnt * (m_pw + 4)));
            m_cnt++;
            if (m_cnt == m_n || fl) begin
                exp_we = 1'b1; exp_data = m_acc; m_acc = '0; m_cnt = 0;
            end
        end else if (fl && m_cnt > 0) begin
            exp_we = 1'b1; exp_data = m_acc; m_acc = '0; m_cnt = 0;
        end
    endtask

    // One cycle: check the previous result, then drive and model new inputs.
    task automatic cyc(input string tag, input logic v, input logic [2:0] st,
                       input logic [15:0] pk, input logic sy, input logic tr,
                       input logic fl, input logic [1:0] cfg);
        @(negedge clk);
        compare(prev_tag);
        smp_valid = v; smp_stat = st; smp_pkt = pk; smp_sync = sy;
        smp_trig = tr; flush = fl; width_cfg = cfg;
        model(v, st, pk, sy, tr, fl, cfg);
        prev_tag = tag;
    endtask

    task automatic idle(input string tag, input logic [1:0] cfg);
        cyc(tag, 1'b0, 3'b111, 16'hFFFF, 1'b1, 1'b1, 1'b0, cfg);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen at the first cycle after reset
        @(negedge clk);
        checks++;
        if (word_we !== 1'b0 || word_data !== 32'h0) begin
            fails++;
            $display("FAIL R1: we=%0b data=%08h expected we=0 data=00000000", word_we, word_data);
        end

        // R2 and R6: 4-bit mode, two full words, packet bits above 3 set
        cyc("R2", 1, 3'd1, 16'hFFF5, 1, 0, 0, 2'b00);
        cyc("R2", 1, 3'd2, 16'h00A3, 0, 0, 0, 2'b00);
        cyc("R2", 1, 3'd7, 16'h000F, 1, 0, 0, 2'b00);
        cyc("R6", 1, 3'd0, 16'h1230, 0, 0, 0, 2'b00);
        cyc("R6", 1, 3'd5, 16'hABCD, 1, 0, 0, 2'b00);
        cyc("R6", 1, 3'd3, 16'h0001, 0, 0, 0, 2'b00);
        idle("R7", 2'b00);
        // R3: 8-bit mode
        cyc("R3", 1, 3'd4, 16'hFF81, 1, 0, 0, 2'b01);
        cyc("R3", 1, 3'd3, 16'h005A, 1, 0, 0, 2'b01);
        cyc("R3", 1, 3'd6, 16'h12FF, 0, 0, 0, 2'b01);
        cyc("R3", 1, 3'd1, 16'h0000, 1, 0, 0, 2'b01);
        idle("R3", 2'b01);
        // R4: 16-bit mode, both codes
        cyc("R4", 1, 3'd5, 16'hBEEF, 1, 0, 0, 2'b10);
        cyc("R4", 1, 3'd2, 16'h1234, 0, 0, 0, 2'b11);
        cyc("R4", 1, 3'd7, 16'hFFFF, 1, 0, 0, 2'b11);
        idle("R4", 2'b10);
        // R5: trigger in every mode
        cyc("R5", 1, 3'd3, 16'h000F, 0, 1, 0, 2'b00);
        cyc("R5", 1, 3'd1, 16'h0000, 1, 0, 0, 2'b00);
        cyc("R5", 1, 3'd5, 16'h0008, 1, 1, 0, 2'b00);
        cyc("R5", 1, 3'd2, 16'h00F8, 0, 1, 0, 2'b01);
        cyc("R5", 1, 3'd0, 16'h0011, 0, 0, 0, 2'b01);
        cyc("R5", 1, 3'd7, 16'hFFF8, 1, 1, 0, 2'b10);
        idle("R5", 2'b10);
        // R7 and R10: gaps with junk on the sample lines
        cyc("R7", 1, 3'd1, 16'h0001, 0, 0, 0, 2'b00);
        idle("R10", 2'b00);
        idle("R10", 2'b00);
        cyc("R7", 1, 3'd2, 16'h0002, 0, 0, 0, 2'b00);
        idle("R10", 2'b00);
        cyc("R7", 1, 3'd3, 16'h0003, 1, 0, 0, 2'b00);
        idle("R7", 2'b00);
        // R8: flush after one and two slots, empty flush, flush with sample
        cyc("R8", 1, 3'd6, 16'h0009, 1, 0, 0, 2'b00);
        cyc("R8", 0, 3'd7, 16'hFFFF, 1, 1, 1, 2'b00);
        cyc("R8", 0, 3'd7, 16'hFFFF, 1, 1, 1, 2'b00);
        cyc("R8", 1, 3'd1, 16'h0004, 0, 0, 0, 2'b00);
        cyc("R8", 1, 3'd2, 16'h0005, 1, 0, 0, 2'b00);
        cyc("R8", 0, 3'd0, 16'h0000, 0, 0, 1, 2'b00);
        cyc("R8", 1, 3'd4, 16'h0077, 1, 0, 0, 2'b01);
        cyc("R8", 1, 3'd5, 16'h0066, 0, 0, 1, 2'b00);
        idle("R8", 2'b00);
        // R9: width code changes inside a word
        cyc("R9", 1, 3'd1, 16'h0003, 0, 0, 0, 2'b00);
        cyc("R9", 1, 3'd2, 16'h00F4, 1, 0, 0, 2'b10);
        cyc("R9", 1, 3'd3, 16'h0005, 0, 0, 0, 2'b01);
        cyc("R9", 1, 3'd4, 16'h00AB, 1, 0, 0, 2'b01);
        cyc("R9", 1, 3'd5, 16'h00CD, 0, 0, 0, 2'b00);
        idle("R9", 2'b00);
        // R7: mixed traffic over all inputs
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc("R7", r[0] | r[1], r[4:2], r[20:5], r[21], r[22] & r[23],
                r[24] & r[25] & r[26], r[28:27]);
        end
        idle("R7", 2'b00);
        idle("R7", 2'b00);
        @(negedge clk);
        compare(prev_tag);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule